// File: doc/BRIEF.md
# Dual-Tag DRAM Cache Lookup Sequencer

This block sequences read lookups for a direct-mapped DRAM cache whose tags live in two places. Each cache line carries its own tag, so a single DRAM read returns both the data and the tag. A separate tag region in DRAM holds the same tags packed several sets to a block, and a small direct-mapped SRAM tag cache buffers recently used blocks of that region. For every request a table of 2-bit saturating counters guesses the outcome. If it guesses a hit, the sequencer reads the line and compares the tag that comes with it. If it guesses a miss, the sequencer checks the SRAM tag cache, fetches the tag block from DRAM when needed, and only reads the line when the tags prove a hit.

Requests arrive one at a time over a valid/ready handshake. The block drives a command port to the DRAM cache and another to main memory. It finishes each request with a one-cycle completion pulse that reports hit or miss, and then trains the counter with the real outcome. When a miss is served from main memory, the line is assumed to be installed in the DRAM cache by the external fill path. The sequencer updates its own tag-cache copy of that set to match.

Top module: `dcTagSeq`

## Requirements
- R1: After reset, `reqReady` is 1, both command valids are 0 and `done` is 0. Every predictor counter holds 01, so the first lookup of any index takes the predicted-miss path.
- R2: A request is taken on a cycle with `reqValid` and `reqReady` both high. `reqReady` is high only while no request is in progress and is low from the cycle after acceptance until the completion pulse. No command is issued while `reqReady` is high.
- R3: Predicted hit with a matching line tag: exactly one DRAM command is issued, of kind 0 (line read), addressed by the set index (address bits [SET_W-1:0]). The request completes as a hit with no main-memory read. The line response carries {valid, tag} in `dcRspData[TAG_W:0]`, with the valid flag at bit TAG_W.
- R4: Predicted hit whose line tag is invalid or different: one line read, then one main-memory read of the full line address. The request completes as a miss.
- R5: Predicted miss whose block is absent from the tag cache: one DRAM command of kind 1 (tag-block read) addressed by the block number (set >> log2(TAGS_PER_BLK)). Slot i of the response sits at `dcRspData[i*(TAG_W+1) +: TAG_W+1]` as {valid, tag} for set block*TAGS_PER_BLK+i. The block is stored in the tag cache, and the lookup then goes on from the stored block.
- R6: Predicted miss whose tag-cache lookup succeeds: a tag match causes exactly one line read and completion as a hit. The embedded tag is not re-checked. A mismatch or invalid slot goes straight to one main-memory read with no DRAM command, and completes as a miss.
- R7: The predictor index is the low log2(PRED_ENTRIES) bits of (set XOR tag). A hit is predicted when the counter's upper bit is 1. Completion increments the counter on a hit and decrements it on a miss, saturating at 11 and 00. `donePredHit` reports the prediction used.
- R8: When a miss completes and the set's tag block is present in the tag cache, the slot for that set is rewritten to {1, request tag}, so a later predicted-miss lookup of that line is a hit with no tag-block read.
- R9: A DRAM or main-memory command keeps its valid, kind and address unchanged until accepted by its ready signal. The two command valids are never high together.
- R10: `done` is a single-cycle pulse. It coincides with exactly one of `hit` and `miss`, and neither of those is high without it.
- R11: The tag cache is direct-mapped on the low log2(TC_ENTRIES) bits of the block number. A block that maps to an occupied entry with a different block number evicts it, and the evicted block must be fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Sequencer idle and accepting |
| reqAddr | input | ADDR_W | Line address {tag, set} |
| dcCmdValid | output | 1 | DRAM cache command present |
| dcCmdReady | input | 1 | DRAM cache command accepted |
| dcCmdKind | output | 1 | 0 line read with tag, 1 tag-block read |
| dcCmdAddr | output | SET_W | Set index (kind 0) or block number (kind 1) |
| dcRspValid | input | 1 | DRAM cache response present |
| dcRspData | input | TAGS_PER_BLK*(TAG_W+1) | Line tag or packed tag block |
| mmCmdValid | output | 1 | Main-memory read command present |
| mmCmdReady | input | 1 | Main-memory command accepted |
| mmCmdAddr | output | ADDR_W | Line address to read |
| mmRspValid | input | 1 | Main-memory read finished |
| done | output | 1 | Completion pulse |
| hit | output | 1 | Completed request was a hit |
| miss | output | 1 | Completed request was a miss |
| donePredHit | output | 1 | Prediction used by the completed request |

## Verification
The properties rely on the environment returning at most one response for each accepted command, and only after that command's handshake. They also rely on the tag region and the in-line tags agreeing, which means every main-memory fill must install the line in both. The bench responders answer each handshake on the following cycle and install the line in their DRAM model whenever they accept a main-memory read. A stall scenario holds each ready low for several cycles, which exercises the held-command rule without breaking these assumptions.

// File: rtl/dcTagPkg.sv
`timescale 1ns/1ps
package dcTagPkg;

  localparam logic CMD_LINE = 1'b0;
  localparam logic CMD_TAGBLK = 1'b1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TC_LOOK,
    ST_TAG_CMD,
    ST_TAG_WAIT,
    ST_DATA_CMD,
    ST_DATA_WAIT,
    ST_MEM_CMD,
    ST_MEM_WAIT,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic fillTc;
    logic installTc;
    logic train;
    logic outcomeHit;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic predHit;
    logic predHitQ;
    logic tcHit;
    logic tcSetHit;
    logic inlineHit;
  } dpFlags_t;

endpackage

// File: rtl/dcTagDatapath.sv
`timescale 1ns/1ps
module dcTagDatapath
  import dcTagPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SET_W        = 8,
  parameter int TAGS_PER_BLK = 4,
  parameter int TC_ENTRIES   = 8,
  parameter int PRED_ENTRIES = 64,
  localparam int TAG_W       = ADDR_W - SET_W,
  localparam int SLOT_W      = TAG_W + 1,
  localparam int RSP_W       = TAGS_PER_BLK * SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dpStrobe_t         strobe,
  input  logic              cmdKind,
  input  logic [RSP_W-1:0]  dcRspData,
  output dpFlags_t          flags,
  output logic [SET_W-1:0]  dcCmdAddr,
  output logic [ADDR_W-1:0] mmCmdAddr
);

  localparam int BSEL_W = $clog2(TAGS_PER_BLK);
  localparam int BLK_W  = SET_W - BSEL_W;
  localparam int TCI_W  = $clog2(TC_ENTRIES);
  localparam int TCT_W  = BLK_W - TCI_W;
  localparam int PIDX_W = $clog2(PRED_ENTRIES);

  // latched request
  logic [ADDR_W-1:0] addrQ;
  logic              predHitQ;

  logic [SET_W-1:0]  setQ;
  logic [TAG_W-1:0]  tagQ;
  logic [BLK_W-1:0]  blkQ;
  logic [BSEL_W-1:0] slotQ;
  logic [TCI_W-1:0]  tcIdx;
  logic [TCT_W-1:0]  tcTagQ;

  assign setQ   = addrQ[SET_W-1:0];
  assign tagQ   = addrQ[ADDR_W-1:SET_W];
  assign blkQ   = setQ[SET_W-1:BSEL_W];
  assign slotQ  = setQ[BSEL_W-1:0];
  assign tcIdx  = blkQ[TCI_W-1:0];
  assign tcTagQ = blkQ[BLK_W-1:TCI_W];

  // hit/miss predictor
  logic [1:0]        predCtr [PRED_ENTRIES];
  logic [PIDX_W-1:0] predIdxIn;
  logic [PIDX_W-1:0] predIdxQ;
  logic [1:0]        ctrCur;
  logic [1:0]        ctrNext;

  assign predIdxIn = reqAddr[PIDX_W-1:0] ^ reqAddr[SET_W +: PIDX_W];
  assign predIdxQ  = addrQ[PIDX_W-1:0] ^ addrQ[SET_W +: PIDX_W];
  assign ctrCur    = predCtr[predIdxQ];

  always_comb begin
    ctrNext = ctrCur;
    if (strobe.outcomeHit) begin
      if (ctrCur != 2'b11) ctrNext = ctrCur + 2'd1;
    end else begin
      if (ctrCur != 2'b00) ctrNext = ctrCur - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      predHitQ <= 1'b0;
      for (int i = 0; i < PRED_ENTRIES; i++) predCtr[i] <= 2'b01;
    end else begin
      if (strobe.latchReq) begin
        addrQ    <= reqAddr;
        predHitQ <= predCtr[predIdxIn][1];
      end
      if (strobe.train) predCtr[predIdxQ] <= ctrNext;
    end
  end

  // SRAM tag cache of packed tag blocks
  logic              tcValid  [TC_ENTRIES];
  logic [TCT_W-1:0]  tcBlkTag [TC_ENTRIES];
  logic [RSP_W-1:0]  tcSlots  [TC_ENTRIES];
  logic [RSP_W-1:0]  tcLine;
  logic [SLOT_W-1:0] slotOf   [TAGS_PER_BLK];
  logic [SLOT_W-1:0] curSlot;
  logic              tcHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TC_ENTRIES; i++) tcValid[i] <= 1'b0;
    end else if (strobe.fillTc) begin
      tcValid[tcIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillTc) begin
      tcBlkTag[tcIdx] <= tcTagQ;
      tcSlots[tcIdx]  <= dcRspData;
    end else if (strobe.installTc && tcHit) begin
      for (int s = 0; s < TAGS_PER_BLK; s++) begin
        if (slotQ == BSEL_W'(s)) tcSlots[tcIdx][s*SLOT_W +: SLOT_W] <= {1'b1, tagQ};
      end
    end
  end

  assign tcLine = tcSlots[tcIdx];

  for (genvar g = 0; g < TAGS_PER_BLK; g++) begin : gSlot
    assign slotOf[g] = tcLine[g*SLOT_W +: SLOT_W];
  end

  assign curSlot = slotOf[slotQ];
  assign tcHit   = tcValid[tcIdx] && (tcBlkTag[tcIdx] == tcTagQ);

  // flags to control
  assign flags.predHit   = predCtr[predIdxIn][1];
  assign flags.predHitQ  = predHitQ;
  assign flags.tcHit     = tcHit;
  assign flags.tcSetHit  = curSlot[TAG_W] && (curSlot[TAG_W-1:0] == tagQ);
  assign flags.inlineHit = dcRspData[TAG_W] && (dcRspData[TAG_W-1:0] == tagQ);

  // command addresses
  assign dcCmdAddr = (cmdKind == CMD_TAGBLK) ? {{BSEL_W{1'b0}}, blkQ} : setQ;
  assign mmCmdAddr = addrQ;

endmodule

// File: rtl/dcTagCtrl.sv
`timescale 1ns/1ps
module dcTagCtrl
  import dcTagPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      dcCmdReady,
  input  logic      dcRspValid,
  input  logic      mmCmdReady,
  input  logic      mmRspValid,
  input  dpFlags_t  flags,
  output logic      reqReady,
  output logic      dcCmdValid,
  output logic      dcCmdKind,
  output logic      mmCmdValid,
  output logic      done,
  output logic      hit,
  output logic      miss,
  output logic      donePredHit,
  output dpStrobe_t strobe
);

  seqState_t state, nextState;
  logic      outcomeHitQ, outcomeHitD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      outcomeHitQ <= 1'b0;
    end else begin
      state       <= nextState;
      outcomeHitQ <= outcomeHitD;
    end
  end

  always_comb begin
    nextState   = state;
    outcomeHitD = outcomeHitQ;
    strobe      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState = flags.predHit ? ST_DATA_CMD : ST_TC_LOOK;
        end
      end
      ST_TC_LOOK: begin
        if (!flags.tcHit)       nextState = ST_TAG_CMD;
        else if (flags.tcSetHit) nextState = ST_DATA_CMD;
        else                    nextState = ST_MEM_CMD;
      end
      ST_TAG_CMD:  if (dcCmdReady) nextState = ST_TAG_WAIT;
      ST_TAG_WAIT: begin
        if (dcRspValid) begin
          strobe.fillTc = 1'b1;
          nextState = ST_TC_LOOK;
        end
      end
      ST_DATA_CMD: if (dcCmdReady) nextState = ST_DATA_WAIT;
      ST_DATA_WAIT: begin
        if (dcRspValid) begin
          // predicted-miss path only reaches here on a proven hit
          if (!flags.predHitQ || flags.inlineHit) begin
            outcomeHitD = 1'b1;
            nextState = ST_FINISH;
          end else begin
            nextState = ST_MEM_CMD;
          end
        end
      end
      ST_MEM_CMD:  if (mmCmdReady) nextState = ST_MEM_WAIT;
      ST_MEM_WAIT: begin
        if (mmRspValid) begin
          outcomeHitD = 1'b0;
          nextState = ST_FINISH;
        end
      end
      ST_FINISH: begin
        strobe.train     = 1'b1;
        strobe.installTc = !outcomeHitQ;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.outcomeHit = outcomeHitQ;
  end

  assign reqReady    = (state == ST_IDLE);
  assign dcCmdValid  = (state == ST_TAG_CMD) || (state == ST_DATA_CMD);
  assign dcCmdKind   = (state == ST_TAG_CMD) ? CMD_TAGBLK : CMD_LINE;
  assign mmCmdValid  = (state == ST_MEM_CMD);
  assign done        = (state == ST_FINISH);
  assign hit         = done && outcomeHitQ;
  assign miss        = done && !outcomeHitQ;
  assign donePredHit = done && flags.predHitQ;

endmodule

// File: rtl/dcTagSeq.sv
`timescale 1ns/1ps
module dcTagSeq
  import dcTagPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SET_W        = 8,
  parameter int TAGS_PER_BLK = 4,
  parameter int TC_ENTRIES   = 8,
  parameter int PRED_ENTRIES = 64,
  localparam int RSP_W       = TAGS_PER_BLK * (ADDR_W - SET_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              dcCmdValid,
  input  logic              dcCmdReady,
  output logic              dcCmdKind,
  output logic [SET_W-1:0]  dcCmdAddr,
  input  logic              dcRspValid,
  input  logic [RSP_W-1:0]  dcRspData,
  output logic              mmCmdValid,
  input  logic              mmCmdReady,
  output logic [ADDR_W-1:0] mmCmdAddr,
  input  logic              mmRspValid,
  output logic              done,
  output logic              hit,
  output logic              miss,
  output logic              donePredHit
);

  dpStrobe_t strobe;
  dpFlags_t  flags;
  logic      predHitQ;

  assign predHitQ = flags.predHitQ;

  dcTagCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .dcCmdReady(dcCmdReady), .dcRspValid(dcRspValid),
    .mmCmdReady(mmCmdReady), .mmRspValid(mmRspValid),
    .flags(flags), .reqReady(reqReady), .dcCmdValid(dcCmdValid),
    .dcCmdKind(dcCmdKind), .mmCmdValid(mmCmdValid), .done(done),
    .hit(hit), .miss(miss), .donePredHit(donePredHit), .strobe(strobe)
  );

  dcTagDatapath #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .TAGS_PER_BLK(TAGS_PER_BLK),
    .TC_ENTRIES(TC_ENTRIES), .PRED_ENTRIES(PRED_ENTRIES)
  ) uDp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .strobe(strobe),
    .cmdKind(dcCmdKind), .dcRspData(dcRspData), .flags(flags),
    .dcCmdAddr(dcCmdAddr), .mmCmdAddr(mmCmdAddr)
  );

endmodule

// File: rtl/dcTagSeqChk.sv
`timescale 1ns/1ps
module dcTagSeqChk #(
  parameter int ADDR_W = 20,
  parameter int SET_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              dcCmdValid,
  input logic              dcCmdReady,
  input logic              dcCmdKind,
  input logic [SET_W-1:0]  dcCmdAddr,
  input logic              mmCmdValid,
  input logic              mmCmdReady,
  input logic [ADDR_W-1:0] mmCmdAddr,
  input logic              done,
  input logic              hit,
  input logic              miss,
  input logic              predHitQ
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!dcCmdValid && !mmCmdValid && !done)); // R2

  AST_PRED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(predHitQ)); // R2

  AST_TAGBLK_ON_PRED_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (dcCmdValid && dcCmdKind) |-> !predHitQ); // R5

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(dcCmdValid && mmCmdValid)); // R9

  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dcCmdValid && !dcCmdReady) |=> (dcCmdValid && $stable(dcCmdKind) && $stable(dcCmdAddr))); // R9

  AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mmCmdValid && !mmCmdReady) |=> (mmCmdValid && $stable(mmCmdAddr))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_OUTCOME_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot({hit, miss})); // R10

  AST_OUTCOME_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (hit || miss) |-> done); // R10

endmodule

bind dcTagSeq dcTagSeqChk #(.ADDR_W(ADDR_W), .SET_W(SET_W)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady),
  .dcCmdValid(dcCmdValid), .dcCmdReady(dcCmdReady), .dcCmdKind(dcCmdKind),
  .dcCmdAddr(dcCmdAddr), .mmCmdValid(mmCmdValid), .mmCmdReady(mmCmdReady),
  .mmCmdAddr(mmCmdAddr), .done(done), .hit(hit), .miss(miss),
  .predHitQ(predHitQ)
);

// File: tb/dcTagSeq_test.sv
`timescale 1ns/1ps
module dcTagSeq_test;

  localparam int ADDR_W = 20;
  localparam int SET_W  = 8;
  localparam int TAG_W  = 12;
  localparam int RSP_W  = 4 * (TAG_W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic dcCmdValid, dcCmdKind;
  logic dcCmdReady = 1'b1;
  logic [SET_W-1:0] dcCmdAddr;
  logic dcRspValid = 1'b0;
  logic [RSP_W-1:0] dcRspData = '0;
  logic mmCmdValid;
  logic mmCmdReady = 1'b1;
  logic [ADDR_W-1:0] mmCmdAddr;
  logic mmRspValid = 1'b0;
  logic done, hit, miss, donePredHit;

  always #2.5 clk = ~clk;

  dcTagSeq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .dcCmdValid(dcCmdValid), .dcCmdReady(dcCmdReady),
    .dcCmdKind(dcCmdKind), .dcCmdAddr(dcCmdAddr), .dcRspValid(dcRspValid),
    .dcRspData(dcRspData), .mmCmdValid(mmCmdValid), .mmCmdReady(mmCmdReady),
    .mmCmdAddr(mmCmdAddr), .mmRspValid(mmRspValid), .done(done), .hit(hit),
    .miss(miss), .donePredHit(donePredHit)
  );

  int checks = 0;
  int fails = 0;
  string curScen = "";

  // reference model state
  logic              mV [256];
  logic [TAG_W-1:0]  mT [256];
  logic [1:0]        mC [64];
  logic              tV [8];
  logic [2:0]        tB [8];

  int nData, nTag, nMm;
  logic [SET_W-1:0]  lastDataAddr, lastTagAddr;
  logic [ADDR_W-1:0] lastMmAddr;
  bit stallMode = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, curScen, what, act, exp);
    end
  endtask

  // DRAM cache responder: answers one cycle after each handshake
  initial begin
    logic [RSP_W-1:0] d;
    forever begin
      @(negedge clk); #0.5;
      dcRspValid = 1'b0;
      if (rstN && dcCmdValid && dcCmdReady) begin
        d = '0;
        if (dcCmdKind) begin
          nTag++;
          lastTagAddr = dcCmdAddr;
          for (int i = 0; i < 4; i++)
            d[i*(TAG_W+1) +: TAG_W+1] = {mV[{dcCmdAddr[5:0], 2'(i)}], mT[{dcCmdAddr[5:0], 2'(i)}]};
        end else begin
          nData++;
          lastDataAddr = dcCmdAddr;
          d[TAG_W:0] = {mV[dcCmdAddr], mT[dcCmdAddr]};
        end
        @(negedge clk); #0.5;
        dcRspValid = 1'b1;
        dcRspData = d;
      end
    end
  end

  // main-memory responder: installs the line in the DRAM model
  initial begin
    forever begin
      @(negedge clk); #0.5;
      mmRspValid = 1'b0;
      if (rstN && mmCmdValid && mmCmdReady) begin
        nMm++;
        lastMmAddr = mmCmdAddr;
        mV[mmCmdAddr[7:0]] = 1'b1;
        mT[mmCmdAddr[7:0]] = mmCmdAddr[19:8];
        @(negedge clk); #0.5;
        mmRspValid = 1'b1;
      end
    end
  end

  task automatic doRequest(input logic [ADDR_W-1:0] a, input string scen);
    logic [7:0]  s      = a[7:0];
    logic [11:0] t      = a[19:8];
    logic [5:0]  blk    = s[7:2];
    logic [2:0]  ti     = blk[2:0];
    logic [2:0]  tt     = blk[5:3];
    logic [5:0]  pi     = a[5:0] ^ a[13:8];
    logic        expPred = mC[pi][1];
    logic        actHit  = mV[s] && (mT[s] == t);
    logic        tcH     = tV[ti] && (tB[ti] == tt);
    int eData, eTag, eMm, cyc, dcStall, mmStall;
    logic [SET_W-1:0] dcHeld;
    logic [ADDR_W-1:0] mmHeld;
    string path;
    curScen = scen;
    if (expPred) begin
      eData = 1; eTag = 0; eMm = actHit ? 0 : 1;
      path = actHit ? "R3" : "R4";
    end else begin
      eTag = tcH ? 0 : 1; eData = actHit ? 1 : 0; eMm = actHit ? 0 : 1;
      path = tcH ? "R6" : "R5";
    end
    nData = 0; nTag = 0; nMm = 0;
    dcStall = 0; mmStall = 0; dcHeld = '0; mmHeld = '0;
    @(negedge clk);
    chk(reqReady == 1'b1, "R2", "ready before request", reqReady, 1);
    reqValid = 1'b1;
    reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R2", "ready while busy", reqReady, 0);
    cyc = 0;
    while (!done && cyc < 300) begin
      if (stallMode && !dcCmdReady && (dcCmdValid || dcStall > 0)) begin
        if (dcStall == 0) dcHeld = dcCmdAddr;
        else chk(dcCmdValid && dcCmdAddr == dcHeld, "R9", "dc command held", dcCmdAddr, dcHeld);
        dcStall++;
        if (dcStall == 4) begin dcCmdReady = 1'b1; dcStall = 0; end
      end else if (stallMode && dcCmdReady && !dcCmdValid) dcCmdReady = 1'b0;
      if (stallMode && !mmCmdReady && (mmCmdValid || mmStall > 0)) begin
        if (mmStall == 0) mmHeld = mmCmdAddr;
        else chk(mmCmdValid && mmCmdAddr == mmHeld, "R9", "mm command held", mmCmdAddr, mmHeld);
        mmStall++;
        if (mmStall == 4) begin mmCmdReady = 1'b1; mmStall = 0; end
      end else if (stallMode && mmCmdReady && !mmCmdValid) mmCmdReady = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R10", "completion seen", done, 1);
    chk(donePredHit == expPred, "R7", "prediction", donePredHit, expPred);
    chk(hit == actHit, path, "hit flag", hit, actHit);
    chk(miss == !actHit, path, "miss flag", miss, !actHit);
    chk(nData == eData, path, "line reads", nData, eData);
    chk(nTag == eTag, path, "tag-block reads", nTag, eTag);
    chk(nMm == eMm, path, "main-memory reads", nMm, eMm);
    if (eData > 0) chk(lastDataAddr == s, path, "line read address", lastDataAddr, s);
    if (eTag > 0) chk(lastTagAddr == {2'b00, blk}, path, "tag-block address", lastTagAddr, blk);
    if (eMm > 0) chk(lastMmAddr == a, path, "main-memory address", lastMmAddr, a);
    @(negedge clk);
    chk(done == 1'b0 && hit == 1'b0 && miss == 1'b0, "R10", "single-cycle pulse", done, 0);
    // model update
    if (actHit) begin if (mC[pi] != 2'b11) mC[pi] = mC[pi] + 2'd1; end
    else begin if (mC[pi] != 2'b00) mC[pi] = mC[pi] - 2'd1; end
    if (!expPred && !tcH) begin tV[ti] = 1'b1; tB[ti] = tt; end
  endtask

  task automatic testReset();
    curScen = "reset";
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(dcCmdValid == 1'b0, "R1", "reset dc valid", dcCmdValid, 0);
    chk(mmCmdValid == 1'b0, "R1", "reset mm valid", mmCmdValid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic testColdAndInstall();
    doRequest(20'h00510, "R1 cold lookup predicts miss");
    doRequest(20'h00510, "R8 install visible in tag cache");
    doRequest(20'h00510, "R7 counter climbs");
    doRequest(20'h00510, "R3 predicted hit");
  endtask

  task automatic testAliasMiss();
    doRequest(20'h04510, "R4 aliasing tag in same set");
    doRequest(20'h00510, "R4 original tag evicted");
  endtask

  task automatic testConflict();
    doRequest(20'h00530, "R11 conflicting block");
    doRequest(20'h00710, "R11 evicted block refetched");
    doRequest(20'h00911, "R6 tag-cache hit, slot empty");
  endtask

  task automatic testWarmFetch();
    mV[8'h40] = 1'b1;
    mT[8'h40] = 12'h007;
    doRequest(20'h00740, "R6 fetched block proves hit");
  endtask

  task automatic testSaturation();
    for (int i = 0; i < 6; i++) doRequest(20'h10022, "R7 saturate high");
    doRequest(20'h14022, "R7 one miss after saturation");
    doRequest(20'h14022, "R7 still predicts hit");
  endtask

  task automatic testStall();
    stallMode = 1'b1;
    dcCmdReady = 1'b0;
    mmCmdReady = 1'b0;
    doRequest(20'h00384, "R9 back-pressure");
    stallMode = 1'b0;
    dcCmdReady = 1'b1;
    mmCmdReady = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mV[i] = 1'b0; mT[i] = '0; end
    for (int i = 0; i < 64; i++) mC[i] = 2'b01;
    for (int i = 0; i < 8; i++) begin tV[i] = 1'b0; tB[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testColdAndInstall();
    testAliasMiss();
    testConflict();
    testWarmFetch();
    testSaturation();
    testStall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule